// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and one 16-bit parallel NOR flash device that accepts the common unlock-prefixed command set. The host hands over one request at a time: a reset, an identification read, a single-word program or a sector erase. The sequencer turns the request into a script of bus write and read cycles. Every command is opened by two fixed unlock writes. Where the device then works on its own, the sequencer polls it for completion and reads the result back to check it.

Completion is detected from a status bit that flips on every read while the device is busy. The operation counts as finished once two reads in a row return the same value of that bit. Polling is bounded, with separate limits for programming and erasing. A finished request is reported by a one-clock done pulse with a status code. For an identification read, the manufacturer and device codes are also returned. For a failed verify, the failing word address is returned.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command starts with data 0x00AA written to word address 0x555, then data 0x0055 to word address 0x2AA, then the command code. A reset request produces exactly these three writes with code 0x00F0 at word address 0x555 and returns status 0 (OK).
- R2: The bus carries byte addresses. The driven address is the word address shifted left by one, so bit 0 is always 0 while the chip is enabled.
- R3: Each write holds the write strobe low for exactly STROBE_CYCLES clocks. Address and data are stable one clock before the strobe falls and in the clock where it rises. The write and output strobes are never low together.
- R4: An ID request enters ID mode (code 0x0090), reads word 0 into mfr_id, issues a reset (0x00F0), enters ID mode again, reads word 1 into dev_id and issues a final reset. This gives twelve writes in total.
- R5: A program request writes the program-setup code 0x00A0 after the unlock pair, then writes the data word to the target word address. A matching read-back gives status 0.
- R6: Completion is declared only when two consecutive polling reads agree in data bit 6. A bit that toggles between reads keeps the sequencer polling.
- R7: If the device keeps toggling, polling gives up and reports status 1 (timeout). Programs allow PROG_POLL_MAX polls and erases allow ERASE_POLL_MAX polls.
- R8: If the word read back after a program differs from the data written, the status is 2 (verify fail) and fail_addr is the target word address.
- R9: An erase request sends code 0x0080 after an unlock pair, then a second unlock pair and code 0x0030 at the sector base. The sector base is the request address with its low log2(SECTOR_WORDS) bits cleared. Every word of the sector is then read and must be 0xFFFF for status 0.
- R10: If any sector word is not 0xFFFF after an erase, the status is 2 and fail_addr is the first such word address in ascending order.
- R11: req_ready is high only when no request is in progress. A request is taken when req_valid and req_ready are both high. Each accepted request yields exactly one one-clock done pulse. Request inputs presented while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_op | input | 2 | 0 reset, 1 ID read, 2 program, 3 sector erase |
| req_addr | input | AW | Target word address (program) or any word in the sector (erase) |
| req_data | input | 16 | Data word to program |
| done | output | 1 | One-clock completion pulse |
| done_status | output | 2 | 0 OK, 1 timeout, 2 verify fail |
| fail_addr | output | AW | Word address of the failed verify |
| mfr_id | output | 16 | Manufacturer code from the last ID request |
| dev_id | output | 16 | Device code from the last ID request |
| flash_addr | output | AW+1 | Byte address to the device |
| flash_dq_out | output | 16 | Write data to the device |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | 16 | Read data from the device |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The bench uses a behavioural flash model that decodes the unlock scripts, stores data with the AND-only behaviour of a real program operation, and toggles bit 6 for a chosen number of reads. The toggle count is set between the two polling limits, so a design that used one limit for both operations would time out an erase that should pass, or pass a program that should time out. Verify faults are planted at the first and last word of a sector: a sweep that skipped an end word, or reported the last address read instead of the failing one, would show a wrong status or address. Unaligned erase addresses catch a design that sends the erase-confirm to the raw address. Strobe widths, the byte-address shift and a request held during a busy operation are all observed on the bus log.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {OP_RESET, OP_ID, OP_PROG, OP_ERASE} op_e;
    typedef enum logic [1:0] {ST_OK, ST_TIMEOUT, ST_VERIFY} stat_e;
    typedef enum logic [2:0] {K_WR, K_RD_MFR, K_RD_DEV, K_POLL, K_CHECK, K_END} kind_e;

    localparam int          KEY_ADDR_A  = 32'h555;
    localparam int          KEY_ADDR_B  = 32'h2AA;
    localparam logic [15:0] KEY_DATA_A  = 16'h00AA;
    localparam logic [15:0] KEY_DATA_B  = 16'h0055;
    localparam logic [15:0] CODE_RESET  = 16'h00F0;
    localparam logic [15:0] CODE_ID     = 16'h0090;
    localparam logic [15:0] CODE_PROG   = 16'h00A0;
    localparam logic [15:0] CODE_ERS_A  = 16'h0080;
    localparam logic [15:0] CODE_ERS_B  = 16'h0030;
    localparam logic [15:0] BLANK_WORD  = 16'hFFFF;
    localparam int          TOGGLE_BIT  = 6;

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
    parameter int AW            = 11,
    parameter int STROBE_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          idle,
    output logic          cyc_done,
    output logic [15:0]   rdata,
    output logic [AW:0]   bus_addr,
    output logic [15:0]   bus_dq_out,
    output logic          bus_dq_oe,
    input  logic [15:0]   bus_dq_in,
    output logic          bus_ce_n,
    output logic          bus_we_n,
    output logic          bus_oe_n
);
    localparam int CNT_W = $clog2(STROBE_CYCLES + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} ph_e;

    typedef struct packed {
        ph_e             ph;
        logic            wr;
        logic [AW-1:0]   addr;
        logic [15:0]     wdata;
        logic [CNT_W-1:0] cnt;
        logic [15:0]     rdata;
    } cyc_t;

    cyc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.ph)
            PH_IDLE: if (start) begin
                c_d.ph    = PH_SETUP;
                c_d.wr    = wr;
                c_d.addr  = addr;
                c_d.wdata = wdata;
                c_d.cnt   = '0;
            end
            PH_SETUP: c_d.ph = PH_STROBE;
            PH_STROBE: begin
                if (c_q.cnt == CNT_W'(STROBE_CYCLES - 1)) begin
                    c_d.ph = PH_HOLD;
                    if (!c_q.wr) c_d.rdata = bus_dq_in;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign idle       = (c_q.ph == PH_IDLE);
    assign cyc_done   = (c_q.ph == PH_HOLD);
    assign rdata      = c_q.rdata;
    assign bus_addr   = {c_q.addr, 1'b0};
    assign bus_dq_out = c_q.wdata;
    assign bus_dq_oe  = c_q.wr && (c_q.ph != PH_IDLE);
    assign bus_ce_n   = (c_q.ph == PH_IDLE);
    assign bus_we_n   = !(c_q.wr && c_q.ph == PH_STROBE);
    assign bus_oe_n   = !(!c_q.wr && c_q.ph == PH_STROBE);

    // R3: strobes exclusive, write data driven during strobe, setup and hold stability
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n));
    a_r3_drive_on_we: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dq_oe);
    a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_dq_out)));
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_dq_out) && !bus_ce_n));

endmodule

// File: rtl/nor_poll_limit.sv
module nor_poll_limit #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q >= limit - 1'b1);

    // R7: the poll count never passes the selected limit
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < limit));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW             = 11,
    parameter int STROBE_CYCLES  = 3,
    parameter int SECTOR_WORDS   = 16,
    parameter int PROG_POLL_MAX  = 16,
    parameter int ERASE_POLL_MAX = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          done,
    output logic [1:0]    done_status,
    output logic [AW-1:0] fail_addr,
    output logic [15:0]   mfr_id,
    output logic [15:0]   dev_id,
    output logic [AW:0]   flash_addr,
    output logic [15:0]   flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [15:0]   flash_dq_in,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n
);
    localparam int SW_W   = $clog2(SECTOR_WORDS);
    localparam int PMAX   = (PROG_POLL_MAX > ERASE_POLL_MAX) ? PROG_POLL_MAX : ERASE_POLL_MAX;
    localparam int CW     = $clog2(PMAX + 1);
    localparam logic [3:0] STEP_END = 4'hF;

    typedef struct packed {
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [15:0]   data;
    } act_t;

    typedef struct packed {
        logic            busy;
        op_e             op;
        logic [AW-1:0]   addr;
        logic [15:0]     data;
        logic [3:0]      step;
        logic            issued;
        logic            have_prev;
        logic            prev6;
        logic [SW_W-1:0] off;
        stat_e           status;
        logic [AW-1:0]   fail_addr;
        logic [15:0]     mfr;
        logic [15:0]     dev;
        logic            done;
    } seq_t;

    function automatic act_t unl(input logic [1:0] idx, input logic [15:0] code,
                                 input logic [AW-1:0] a);
        act_t r;
        r.kind = K_WR;
        unique case (idx)
            2'd0:    begin r.addr = AW'(KEY_ADDR_A); r.data = KEY_DATA_A; end
            2'd1:    begin r.addr = AW'(KEY_ADDR_B); r.data = KEY_DATA_B; end
            default: begin r.addr = a;               r.data = code;       end
        endcase
        return r;
    endfunction

    function automatic act_t script(input seq_t s);
        act_t          r;
        logic [AW-1:0] key, base, pick;
        key  = AW'(KEY_ADDR_A);
        base = {s.addr[AW-1:SW_W], {SW_W{1'b0}}};
        pick = {s.addr[AW-1:SW_W], s.off};
        r    = '{kind: K_END, addr: '0, data: '0};
        unique case (s.op)
            OP_RESET: if (s.step < 4'd3) r = unl(2'(s.step), CODE_RESET, key);
            OP_ID: begin
                if      (s.step < 4'd3)   r = unl(2'(s.step), CODE_ID, key);
                else if (s.step == 4'd3)  r = '{kind: K_RD_MFR, addr: AW'(0), data: '0};
                else if (s.step < 4'd7)   r = unl(2'(s.step - 4'd4), CODE_RESET, key);
                else if (s.step < 4'd10)  r = unl(2'(s.step - 4'd7), CODE_ID, key);
                else if (s.step == 4'd10) r = '{kind: K_RD_DEV, addr: AW'(1), data: '0};
                else if (s.step < 4'd14)  r = unl(2'(s.step - 4'd11), CODE_RESET, key);
            end
            OP_PROG: begin
                if      (s.step < 4'd3)  r = unl(2'(s.step), CODE_PROG, key);
                else if (s.step == 4'd3) r = '{kind: K_WR,    addr: s.addr, data: s.data};
                else if (s.step == 4'd4) r = '{kind: K_POLL,  addr: s.addr, data: '0};
                else if (s.step == 4'd5) r = '{kind: K_CHECK, addr: s.addr, data: s.data};
            end
            default: begin
                if      (s.step < 4'd3)  r = unl(2'(s.step), CODE_ERS_A, key);
                else if (s.step < 4'd6)  r = unl(2'(s.step - 4'd3), CODE_ERS_B, base);
                else if (s.step == 4'd6) r = '{kind: K_POLL,  addr: base, data: '0};
                else if (s.step == 4'd7) r = '{kind: K_CHECK, addr: pick, data: BLANK_WORD};
            end
        endcase
        return r;
    endfunction

    seq_t          s_d, s_q;
    act_t          act;
    logic          eng_start, eng_idle, eng_done;
    logic [15:0]   eng_rdata;
    logic          tmr_clr, tmr_tick, tmr_last;
    logic [CW-1:0] tmr_limit;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        eng_start = 1'b0;
        tmr_clr   = 1'b0;
        tmr_tick  = 1'b0;
        act       = script(s_q);
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy      = 1'b1;
                s_d.op        = op_e'(req_op);
                s_d.addr      = req_addr;
                s_d.data      = req_data;
                s_d.step      = '0;
                s_d.issued    = 1'b0;
                s_d.have_prev = 1'b0;
                s_d.off       = '0;
                s_d.status    = ST_OK;
                s_d.fail_addr = '0;
                tmr_clr       = 1'b1;
            end
        end else if (act.kind == K_END) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end else if (!s_q.issued) begin
            if (eng_idle) begin
                eng_start  = 1'b1;
                s_d.issued = 1'b1;
            end
        end else if (eng_done) begin
            s_d.issued = 1'b0;
            unique case (act.kind)
                K_RD_MFR: begin s_d.mfr = eng_rdata; s_d.step = s_q.step + 1'b1; end
                K_RD_DEV: begin s_d.dev = eng_rdata; s_d.step = s_q.step + 1'b1; end
                K_POLL: begin
                    if (s_q.have_prev && eng_rdata[TOGGLE_BIT] == s_q.prev6) begin
                        s_d.step = s_q.step + 1'b1;
                    end else if (tmr_last) begin
                        s_d.status = ST_TIMEOUT;
                        s_d.step   = STEP_END;
                    end else begin
                        s_d.have_prev = 1'b1;
                        s_d.prev6     = eng_rdata[TOGGLE_BIT];
                        tmr_tick      = 1'b1;
                    end
                end
                K_CHECK: begin
                    if (eng_rdata != act.data) begin
                        s_d.status    = ST_VERIFY;
                        s_d.fail_addr = act.addr;
                        s_d.step      = STEP_END;
                    end else if (s_q.op == OP_ERASE && s_q.off != SW_W'(SECTOR_WORDS - 1)) begin
                        s_d.off = s_q.off + 1'b1;
                    end else begin
                        s_d.step = s_q.step + 1'b1;
                    end
                end
                default: s_d.step = s_q.step + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{op: OP_RESET, status: ST_OK, default: '0};
        else        s_q <= s_d;
    end

    assign tmr_limit = CW'((s_q.op == OP_ERASE) ? ERASE_POLL_MAX : PROG_POLL_MAX);

    nor_poll_limit #(.CW(CW)) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    nor_bus_cycle #(.AW(AW), .STROBE_CYCLES(STROBE_CYCLES)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .wr         (act.kind == K_WR),
        .addr       (act.addr),
        .wdata      (act.data),
        .idle       (eng_idle),
        .cyc_done   (eng_done),
        .rdata      (eng_rdata),
        .bus_addr   (flash_addr),
        .bus_dq_out (flash_dq_out),
        .bus_dq_oe  (flash_dq_oe),
        .bus_dq_in  (flash_dq_in),
        .bus_ce_n   (flash_ce_n),
        .bus_we_n   (flash_we_n),
        .bus_oe_n   (flash_oe_n)
    );

    assign req_ready   = !s_q.busy;
    assign done        = s_q.done;
    assign done_status = s_q.status;
    assign fail_addr   = s_q.fail_addr;
    assign mfr_id      = s_q.mfr;
    assign dev_id      = s_q.dev;

    // R11: single done pulse per request, acceptance makes the block busy
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r11_bus_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !done) |-> flash_we_n);
    // R2: byte address is even while the chip is selected
    a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> !flash_addr[0]);
    // R7: timeouts only come from operations that poll
    a_r7_timeout_src: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == ST_TIMEOUT) |-> (s_q.op == OP_PROG || s_q.op == OP_ERASE));
    // R8: verify failures only come from program or erase
    a_r8_verify_src: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == ST_VERIFY) |-> (s_q.op == OP_PROG || s_q.op == OP_ERASE));

endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 11;
    localparam int STB = 3;
    localparam int SEC = 16;
    localparam int PPM = 16;
    localparam int EPM = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          done;
    logic [1:0]    done_status;
    logic [AW-1:0] fail_addr;
    logic [15:0]   mfr_id, dev_id;
    logic [AW:0]   flash_addr;
    logic [15:0]   flash_dq_out, flash_dq_in;
    logic          flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_seq #(.AW(AW), .STROBE_CYCLES(STB), .SECTOR_WORDS(SEC),
                  .PROG_POLL_MAX(PPM), .ERASE_POLL_MAX(EPM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .done(done), .done_status(done_status), .fail_addr(fail_addr),
        .mfr_id(mfr_id), .dev_id(dev_id), .flash_addr(flash_addr),
        .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
    );

    // ---------------- behavioural flash model ----------------
    logic [15:0]   mem [0:(1<<AW)-1];
    logic          bd_we = 1'b0;
    logic [AW-1:0] bd_a = '0;
    logic [15:0]   bd_d = '0;
    logic          kill_busy = 1'b0, clr_log = 1'b0;
    int            busy_len = 4;
    logic          bad_en = 1'b0;
    logic [AW-1:0] bad_a = '0;
    logic [15:0]   id_m = 16'h0, id_d = 16'h0;

    logic          we_p = 1'b1, oe_p = 1'b1;
    int            busy_cnt = 0, wcnt = 0, wlen = 0;
    logic          tog = 1'b0, id_mode = 1'b0, prog_arm = 1'b0, ers_arm = 1'b0;
    logic          odd_seen = 1'b0, width_bad = 1'b0;
    int            cyc = 0;
    logic [AW-1:0] wlog_a [0:31];
    logic [15:0]   wlog_d [0:31];
    logic [AW-1:0] wa;

    assign wa = flash_addr[AW:1];

    always_comb begin
        if (busy_cnt != 0)  flash_dq_in = {9'd0, tog, 6'd0};
        else if (id_mode)   flash_dq_in = (wa == 0) ? id_m : ((wa == 1) ? id_d : 16'h0);
        else                flash_dq_in = mem[wa];
    end

    always @(posedge clk) begin
        we_p <= flash_we_n;
        oe_p <= flash_oe_n;
        if (bd_we) mem[bd_a] <= bd_d;
        if (!flash_ce_n && flash_addr[0]) odd_seen <= 1'b1;
        if (!flash_we_n) wlen <= wlen + 1;
        if (clr_log) begin
            wcnt <= 0; odd_seen <= 1'b0; width_bad <= 1'b0;
        end
        if (kill_busy) busy_cnt <= 0;
        else if (!oe_p && flash_oe_n && busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
            tog      <= ~tog;
        end
        if (!we_p && flash_we_n) begin
            wlen <= 0;
            if (wlen != STB) width_bad <= 1'b1;
            if (wcnt < 32) begin
                wlog_a[wcnt] <= wa;
                wlog_d[wcnt] <= flash_dq_out;
            end
            wcnt <= wcnt + 1;
            if (prog_arm) begin
                mem[wa]  <= mem[wa] & flash_dq_out;
                busy_cnt <= busy_len;
                prog_arm <= 1'b0;
                cyc      <= 0;
            end else if (cyc == 0) begin
                cyc <= (wa == 11'h555 && flash_dq_out == 16'h00AA) ? 1 : 0;
            end else if (cyc == 1) begin
                cyc <= (wa == 11'h2AA && flash_dq_out == 16'h0055) ? 2 : 0;
            end else begin
                cyc <= 0;
                if (ers_arm && flash_dq_out == 16'h0030) begin
                    for (int k = 0; k < SEC; k++) begin
                        logic [AW-1:0] ea;
                        ea = {wa[AW-1:4], 4'(k)};
                        mem[ea] <= (bad_en && ea == bad_a) ? 16'h0000 : 16'hFFFF;
                    end
                    busy_cnt <= busy_len;
                    ers_arm  <= 1'b0;
                end else if (wa == 11'h555) begin
                    case (flash_dq_out)
                        16'h00F0: id_mode  <= 1'b0;
                        16'h0090: id_mode  <= 1'b1;
                        16'h00A0: prog_arm <= 1'b1;
                        16'h0080: ers_arm  <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_tests = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bd(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); bd_we = 1'b1; bd_a = a; bd_d = d;
        @(negedge clk); bd_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_log = 1'b1; kill_busy = 1'b1;
        @(negedge clk); clr_log = 1'b0; kill_busy = 1'b0;
    endtask

    task automatic run(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [15:0] d, input int hold);
        pulse_clr();
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        chk("R11 busy after accept", req_ready, 1'b0);
        req_op = 2'd0; req_addr = ~a; req_data = ~d;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R11 ready low while busy", req_ready, 1'b0);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R11 done is one pulse", done, 1'b0);
    endtask

    task automatic chk_unlock(input int base, input logic [15:0] code,
                              input logic [AW-1:0] a, input string req);
        chk({req, " unlock A addr"}, wlog_a[base],     11'h555);
        chk({req, " unlock A data"}, wlog_d[base],     16'h00AA);
        chk({req, " unlock B addr"}, wlog_a[base + 1], 11'h2AA);
        chk({req, " unlock B data"}, wlog_d[base + 1], 16'h0055);
        chk({req, " code addr"},     wlog_a[base + 2], a);
        chk({req, " code data"},     wlog_d[base + 2], code);
    endtask

    task automatic main_seq();
        logic [1:0] st;
        repeat (3) @(negedge clk);
        // R11 R3: idle state after reset
        chk("R11 ready after reset", req_ready, 1'b1);
        chk("R11 no done after reset", done, 1'b0);
        chk("R3 strobes idle after reset", {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'b1110);

        // R1: reset request
        run(2'd0, 11'h123, 16'h0, 0);
        chk("R1 reset status", done_status, 2'd0);
        chk("R1 reset write count", wcnt, 3);
        chk_unlock(0, 16'h00F0, 11'h555, "R1");

        // R4: identification sweep
        for (int i = 0; i < 3; i++) begin
            logic [15:0] m, dv;
            m  = 16'h00A5 + 16'(i * 16'h1357);
            dv = 16'h1234 ^ 16'(i * 16'h0F0F);
            @(negedge clk); id_m = m; id_d = dv;
            run(2'd1, 11'h0, 16'h0, 0);
            chk("R4 mfr code", mfr_id, m);
            chk("R4 dev code", dev_id, dv);
            chk("R4 write count", wcnt, 12);
            chk_unlock(0, 16'h0090, 11'h555, "R4");
            chk_unlock(3, 16'h00F0, 11'h555, "R4");
            chk_unlock(6, 16'h0090, 11'h555, "R4");
            chk_unlock(9, 16'h00F0, 11'h555, "R4");
            chk("R4 back in read mode", id_mode, 1'b0);
        end

        // R5 R6 R2 R3: program sweep with varying busy lengths
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            logic [15:0]   d;
            a = 11'(i * 11'h0F3 + 7);
            d = 16'hC3A5 ^ 16'(i * 16'h1111);
            bd(a, 16'hFFFF);
            @(negedge clk); busy_len = 2 + i;
            run(2'd2, a, d, 0);
            chk("R5 program status", done_status, 2'd0);
            chk("R5 program writes", wcnt, 4);
            chk_unlock(0, 16'h00A0, 11'h555, "R5");
            chk("R5 data addr", wlog_a[3], a);
            chk("R5 data word", wlog_d[3], d);
            chk("R5 stored word", mem[a], d);
            chk("R6 done only after toggling stops", busy_cnt, 0);
            chk("R2 no odd byte address", odd_seen, 1'b0);
            chk("R3 strobe width", width_bad, 1'b0);
        end

        // R6: zero busy reads still needs two agreeing reads
        bd(11'h040, 16'hFFFF);
        @(negedge clk); busy_len = 0;
        run(2'd2, 11'h040, 16'h5A5A, 0);
        chk("R6 immediate stable status", done_status, 2'd0);

        // R8: verify failure from AND-only programming
        bd(11'h077, 16'h00FF);
        @(negedge clk); busy_len = 3;
        run(2'd2, 11'h077, 16'hFF00, 0);
        chk("R8 verify status", done_status, 2'd2);
        chk("R8 fail address", fail_addr, 11'h077);

        // R7: program times out where erase would not
        bd(11'h100, 16'hFFFF);
        @(negedge clk); busy_len = 30;
        run(2'd2, 11'h100, 16'h1111, 0);
        chk("R7 program timeout", done_status, 2'd1);
        @(negedge clk); busy_len = 30;
        run(2'd3, 11'h100, 16'h0, 0);
        chk("R7 erase outlasts program limit", done_status, 2'd0);
        @(negedge clk); busy_len = 100;
        run(2'd3, 11'h100, 16'h0, 0);
        chk("R7 erase timeout", done_status, 2'd1);

        // R9: erase sweep, unaligned request addresses
        for (int s = 0; s < 6; s++) begin
            logic [AW-1:0] base;
            base = 11'(SEC * (s * 7 + 1));
            for (int k = 0; k < SEC; k++) bd(base + 11'(k), 16'(k * 16'h0101));
            @(negedge clk); busy_len = 5 + s; bad_en = 1'b0;
            run(2'd3, base + 11'(s * 2 + 1), 16'h0, 0);
            chk("R9 erase status", done_status, 2'd0);
            chk("R9 erase writes", wcnt, 6);
            chk_unlock(0, 16'h0080, 11'h555, "R9");
            chk_unlock(3, 16'h0030, base, "R9");
            chk("R9 sector blank", mem[base + 11'(SEC - 1)], 16'hFFFF);
        end

        // R10: bad word at first and last sector position
        for (int j = 0; j < 2; j++) begin
            logic [AW-1:0] base, bad;
            base = 11'h300;
            bad  = base + ((j == 0) ? 11'd0 : 11'(SEC - 1));
            @(negedge clk); busy_len = 4; bad_en = 1'b1; bad_a = bad;
            run(2'd3, base + 11'd9, 16'h0, 0);
            chk("R10 erase verify status", done_status, 2'd2);
            chk("R10 erase fail address", fail_addr, bad);
        end
        @(negedge clk); bad_en = 1'b0;

        // R11: request held during a busy program has no effect
        bd(11'h222, 16'hFFFF);
        @(negedge clk); busy_len = 6;
        run(2'd2, 11'h222, 16'h0F0F, 8);
        chk("R11 held request ignored status", done_status, 2'd0);
        chk("R11 held request no extra writes", wcnt, 4);
        chk("R11 held request data kept", mem[11'h222], 16'h0F0F);
        repeat (4) @(negedge clk);
        chk("R11 idle again", req_ready, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule